// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Translator

This block sits between a console's CPU and video buses and the program and character ROMs of a game cartridge. The CPU programs it by writing into the upper half of its address space, `$8000-$FFFF`. Those writes land in a small register file. The register file holds an index-plus-modes register, eight bank slots and a mirroring bit. From that state, the block turns every CPU and video-bus address into a wider physical ROM address.

Program ROM is seen through four 8 KB windows. Two of these windows can be switched, one is pinned to the second-last bank, and one is pinned to the last bank. A mode bit decides whether the first window or the third window is the pinned one.

Character ROM is seen as two 2 KB banks and four 1 KB banks. A second mode bit decides which 4 KB half of the video space holds the 2 KB pair. A single register bit tells the nametable logic whether to mirror horizontally or vertically.

Top module: `cart_bank_xlate`

## Requirements
- R1: After reset, every bank slot, both mode bits and the mirroring bit read as zero. As a result, CPU `$8000` and `$A000` map to bank 0, `$C000` maps to bank 62, `$E000` maps to bank 63, and every character region maps to bank 0 (the 2 KB regions map to `{0, video A10}`).
- R2: A write only takes effect when CPU A15 is 1. A write below `$8000` changes no state. A write to `$C000-$FFFF` also changes no state. A write to an odd address in `$A000-$BFFF` changes no state.
- R3: A write to an even address in `$8000-$9FFF` stores three things. Data bits [2:0] become the slot index, bit 6 becomes the program-window mode, and bit 7 becomes the character-half mode.
- R4: A write to an odd address in `$8000-$9FFF` stores the data byte into the slot named by the current index, and into no other slot.
- R5: With program mode 0, these mappings hold:
  - CPU `$8000-$9FFF` maps to slot 6.
  - `$A000-$BFFF` maps to slot 7.
  - `$C000-$DFFF` maps to bank 62 (second-last).
  - Only the low 6 bits of a program slot are used.
  - The physical program address is `{bank[5:0], cpu_addr[12:0]}`.
- R6: With program mode 1, `$C000-$DFFF` maps to slot 6 and `$8000-$9FFF` maps to bank 62. `$A000-$BFFF` still maps to slot 7.
- R7: CPU `$E000-$FFFF` always maps to bank 63, whatever the mode and slot contents.
- R8: With character mode 0, video `$0000-$07FF` uses slot 0 and `$0800-$0FFF` uses slot 1. For these two 2 KB regions, the bank is the slot value with bit 0 replaced by video A10. Video `$1000-$1FFF` uses slots 2, 3, 4 and 5 in ascending 1 KB steps. The physical character address is `{bank[7:0], ppu_addr[9:0]}`.
- R9: With character mode 1, video A12 is inverted before the decode in R8. The 1 KB slots 2-5 then cover `$0000-$0FFF`, and the 2 KB slots 0-1 cover `$1000-$1FFF`.
- R10: A write to an even address in `$A000-$BFFF` sets `mirror_horiz` to data bit 0 (0 = vertical, 1 = horizontal). No other write changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-side clock; register writes are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| ppu_addr | input | 13 | Video-bus pattern-table address |
| prg_addr | output | 19 | Physical program-ROM address `{bank, cpu_addr[12:0]}` |
| chr_addr | output | 18 | Physical character-ROM address `{bank, ppu_addr[9:0]}` |
| mirror_horiz | output | 1 | Nametable mirroring: 1 horizontal, 0 vertical |

## Verification
Several properties are checked on every cycle by the assertions:
- `$E000` always maps to bank 63.
- The pinned middle window always maps to bank 62, in whichever place the program mode puts it.
- A 2 KB character region always passes video A10 through as bank bit 0.
- At most one slot write-enable is active at a time.
- Writes below `$8000` leave all state unchanged, and the mirroring bit holds unless its own register is written.

Some behaviours can only be shown by the bench's scenarios, where it compares every window against its own model. These are the exact slot contents reached after a sequence of index and data writes, the swap of both mode bits, and the reset values.

// File: rtl/cart_xlate_pkg.sv
package cart_xlate_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DATA_W     = 8;
  localparam int PRG_BANK_W = 6;
  localparam int CHR_BANK_W = 8;
  localparam int CHR_SLOTS  = 6;
  localparam int PRG_SLOTS  = 2;
  localparam int NUM_SLOTS  = CHR_SLOTS + PRG_SLOTS;
  localparam int IDX_W      = $clog2(NUM_SLOTS);
  localparam int WIN_OFS_W  = 13;
  localparam int KB1_OFS_W  = 10;

  typedef enum logic [1:0] {
    WIN_LO  = 2'd0,
    WIN_MID = 2'd1,
    WIN_UP  = 2'd2,
    WIN_TOP = 2'd3
  } cpu_win_e;

  // Program bank for a CPU window; swap moves the pinned second-last bank
  // from the upper-middle window to the lowest one.
  function automatic logic [PRG_BANK_W-1:0] prg_bank_pick(
    input cpu_win_e               win,
    input logic                   swap,
    input logic [PRG_BANK_W-1:0]  sw_lo,
    input logic [PRG_BANK_W-1:0]  sw_mid
  );
    logic [PRG_BANK_W-1:0] last_bank;
    logic [PRG_BANK_W-1:0] penult_bank;
    last_bank   = '1;
    penult_bank = last_bank - PRG_BANK_W'(1);
    unique case (win)
      WIN_LO:  prg_bank_pick = swap ? penult_bank : sw_lo;
      WIN_MID: prg_bank_pick = sw_mid;
      WIN_UP:  prg_bank_pick = swap ? sw_lo : penult_bank;
      default: prg_bank_pick = last_bank;
    endcase
  endfunction

  // Slot index used for a video address (A12..A10).
  function automatic logic [IDX_W-1:0] chr_slot_of(
    input logic [2:0] a12_10,
    input logic       swap
  );
    logic half;
    half = a12_10[2] ^ swap;
    if (half) chr_slot_of = IDX_W'(2) + IDX_W'(a12_10[1:0]);
    else      chr_slot_of = IDX_W'(a12_10[1]);
  endfunction

  // A 2 KB region takes its lowest bank bit from video A10.
  function automatic logic [CHR_BANK_W-1:0] chr_fold_2k(
    input logic [CHR_BANK_W-1:0] val,
    input logic                  a10
  );
    chr_fold_2k = {val[CHR_BANK_W-1:1], a10};
  endfunction
endpackage

// File: rtl/bank_regfile.sv
module bank_regfile
  import cart_xlate_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr,
  input  logic                                 in_win,
  input  logic [1:0]                           win,
  input  logic                                 a0,
  input  logic [DATA_W-1:0]                    data,
  output logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_slots,
  output logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_slots,
  output logic                                 prg_swap,
  output logic                                 chr_swap,
  output logic                                 mirror_h
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [IDX_W-1:0]     slot_idx;
  logic                 sel_wr;
  logic                 bank_wr;
  logic                 mir_wr;
  logic [NUM_SLOTS-1:0] slot_we;

  always_comb begin
    sel_wr  = wr && in_win && (cpu_win_e'(win) == WIN_LO)  && !a0;
    bank_wr = wr && in_win && (cpu_win_e'(win) == WIN_LO)  &&  a0;
    mir_wr  = wr && in_win && (cpu_win_e'(win) == WIN_MID) && !a0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_idx <= '0;
      prg_swap <= 1'b0;
      chr_swap <= 1'b0;
    end else if (sel_wr) begin
      slot_idx <= data[IDX_W-1:0];
      prg_swap <= data[6];
      chr_swap <= data[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mirror_h <= 1'b0;
    else if (mir_wr) mirror_h <= data[0];
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_we[i] = bank_wr && (slot_idx == IDX_W'(i));
    if (i < CHR_SLOTS) begin : g_chr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          chr_slots[i] <= '0;
        else if (slot_we[i]) chr_slots[i] <= data[CHR_BANK_W-1:0];
      end
    end else begin : g_prg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          prg_slots[i-CHR_SLOTS] <= '0;
        else if (slot_we[i]) prg_slots[i-CHR_SLOTS] <= data[PRG_BANK_W-1:0];
      end
    end
  end

  AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we)); // R4

  AST_LOW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |=> ($stable(chr_slots) && $stable(prg_slots) && $stable(prg_swap)
                 && $stable(chr_swap) && $stable(mirror_h))); // R2

  AST_MIRROR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mir_wr |=> $stable(mirror_h)); // R10
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
  import cart_xlate_pkg::*;
(
  input  logic [1:0]                           win,
  input  logic                                 prg_swap,
  input  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_slots,
  output logic [PRG_BANK_W-1:0]                bank
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb bank = prg_bank_pick(cpu_win_e'(win), prg_swap, prg_slots[0], prg_slots[1]);
endmodule

// File: rtl/chr_window_map.sv
module chr_window_map
  import cart_xlate_pkg::*;
(
  input  logic [2:0]                           a12_10,
  input  logic                                 chr_swap,
  input  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_slots,
  output logic [CHR_BANK_W-1:0]                bank
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = chr_slot_of(a12_10, chr_swap);
    if (idx < IDX_W'(2)) bank = chr_fold_2k(chr_slots[idx], a12_10[0]);
    else                 bank = chr_slots[idx];
  end
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
  import cart_xlate_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [15:0]                      cpu_addr,
  input  logic [DATA_W-1:0]                cpu_data,
  input  logic                             cpu_wr,
  input  logic [12:0]                      ppu_addr,
  output logic [PRG_BANK_W+WIN_OFS_W-1:0]  prg_addr,
  output logic [CHR_BANK_W+KB1_OFS_W-1:0]  chr_addr,
  output logic                             mirror_horiz
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_slots;
  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_slots;
  logic                                 prg_swap;
  logic                                 chr_swap;
  logic [PRG_BANK_W-1:0]                prg_bank;
  logic [CHR_BANK_W-1:0]                chr_bank;

  bank_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cpu_wr),
    .in_win    (cpu_addr[15]),
    .win       (cpu_addr[14:13]),
    .a0        (cpu_addr[0]),
    .data      (cpu_data),
    .chr_slots (chr_slots),
    .prg_slots (prg_slots),
    .prg_swap  (prg_swap),
    .chr_swap  (chr_swap),
    .mirror_h  (mirror_horiz)
  );

  prg_window_map u_prg (
    .win       (cpu_addr[14:13]),
    .prg_swap  (prg_swap),
    .prg_slots (prg_slots),
    .bank      (prg_bank)
  );

  chr_window_map u_chr (
    .a12_10    (ppu_addr[12:10]),
    .chr_swap  (chr_swap),
    .chr_slots (chr_slots),
    .bank      (chr_bank)
  );

  assign prg_addr = {prg_bank, cpu_addr[WIN_OFS_W-1:0]};
  assign chr_addr = {chr_bank, ppu_addr[KB1_OFS_W-1:0]};

  AST_TOP_WINDOW_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (prg_addr[PRG_BANK_W+WIN_OFS_W-1:WIN_OFS_W] == '1)); // R7

  AST_PINNED_PENULT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15] && cpu_addr[14:13] == (prg_swap ? 2'd0 : 2'd2))
      |-> (prg_addr[PRG_BANK_W+WIN_OFS_W-1:WIN_OFS_W] == {{(PRG_BANK_W-1){1'b1}}, 1'b0})); // R6

  AST_2K_TAKES_A10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ppu_addr[12] ^ chr_swap) == 1'b0) |-> (chr_addr[KB1_OFS_W] == ppu_addr[10])); // R8
endmodule

// File: tb/sim_cart_bank_xlate.sv
module sim_cart_bank_xlate;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [12:0] ppu_addr = '0;
  logic [18:0] prg_addr;
  logic [17:0] chr_addr;
  logic        mirror_horiz;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_slot [8];
  logic [2:0] m_idx;
  logic       m_prgsw, m_chrsw, m_mir;

  always #2 clk = ~clk;

  cart_bank_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
    .chr_addr(chr_addr), .mirror_horiz(mirror_horiz)
  );

  function automatic logic [18:0] want_prg(input logic [15:0] a);
    logic [5:0] b;
    if (a[14:13] == 2'b11)      b = 6'd63;
    else if (a[14:13] == 2'b01) b = m_slot[7][5:0];
    else if (a[14] == m_prgsw)  b = m_slot[6][5:0];
    else                        b = 6'd62;
    return {b, a[12:0]};
  endfunction

  function automatic logic [17:0] want_chr(input logic [12:0] p);
    logic [7:0] b;
    if ((p[12] ^ m_chrsw) == 1'b0) b = (m_slot[p[11]] & 8'hFE) | {7'd0, p[10]};
    else                           b = m_slot[4'd2 + {2'd0, p[11:10]}];
    return {b, p[9:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(posedge clk);
    #1 cpu_wr = 1'b0;
    if (a[15]) begin
      case ({a[14:13], a[0]})
        3'b000: begin m_idx = d[2:0]; m_prgsw = d[6]; m_chrsw = d[7]; end
        3'b001: m_slot[m_idx] = d;
        3'b010: m_mir = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic probe_prg(input logic [15:0] a, input string tag);
    cpu_addr = a; #1;
    check(prg_addr == want_prg(a), tag, 32'(prg_addr), 32'(want_prg(a)));
  endtask

  task automatic probe_chr(input logic [12:0] p, input string tag);
    ppu_addr = p; #1;
    check(chr_addr == want_chr(p), tag, 32'(chr_addr), 32'(want_chr(p)));
  endtask

  task automatic probe_all(input string tag);
    for (int w = 0; w < 4; w++) probe_prg(16'h8000 + 16'(w) * 16'h2000 + 16'h0123, tag);
    for (int r = 0; r < 8; r++) probe_chr(13'(r) * 13'h400 + 13'h05A, tag);
    check(mirror_horiz == m_mir, tag, 32'(mirror_horiz), 32'(m_mir));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) m_slot[i] = '0;
    m_idx = '0; m_prgsw = 0; m_chrsw = 0; m_mir = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    probe_prg(16'h8000, "R1"); probe_prg(16'hA000, "R1");
    cpu_addr = 16'hC000; #1 check(prg_addr[18:13] == 6'd62, "R1", 32'(prg_addr[18:13]), 32'd62);
    cpu_addr = 16'hE000; #1 check(prg_addr[18:13] == 6'd63, "R1", 32'(prg_addr[18:13]), 32'd63);
    ppu_addr = 13'h0400; #1 check(chr_addr == 18'h00400, "R1", 32'(chr_addr), 32'h400);
    check(mirror_horiz == 1'b0, "R1", 32'(mirror_horiz), 0);

    // R3 R4: fill all slots through index then data
    for (int i = 0; i < 8; i++) begin
      cpu_write(16'h8000, 8'(i));
      cpu_write(16'h8001, 8'hA0 + 8'(i) * 8'h03);
    end
    probe_all("R3/R4/R5/R8");
    // R8 odd value in 2 KB slot: bit 0 from A10
    cpu_write(16'h8000, 8'h00);
    cpu_write(16'h9FFF, 8'h37);
    ppu_addr = 13'h0000; #1 check(chr_addr[17:10] == 8'h36, "R8", 32'(chr_addr[17:10]), 32'h36);
    ppu_addr = 13'h0400; #1 check(chr_addr[17:10] == 8'h37, "R8", 32'(chr_addr[17:10]), 32'h37);
    // R5 prg slot uses low 6 bits only
    cpu_write(16'h8006, 8'h06);
    cpu_write(16'h8007, 8'hFF);
    cpu_addr = 16'h8000; #1 check(prg_addr[18:13] == 6'h3F, "R5", 32'(prg_addr[18:13]), 32'h3F);
    cpu_write(16'h8001, 8'hC5);
    probe_all("R5");
    // R6 R7 program mode swap
    cpu_write(16'h8000, 8'h46);
    cpu_addr = 16'h8000; #1 check(prg_addr[18:13] == 6'd62, "R6", 32'(prg_addr[18:13]), 32'd62);
    cpu_addr = 16'hC000; #1 check(prg_addr[18:13] == 6'h05, "R6", 32'(prg_addr[18:13]), 32'h05);
    cpu_addr = 16'hFFFF; #1 check(prg_addr[18:13] == 6'd63, "R7", 32'(prg_addr[18:13]), 32'd63);
    // R9 character half swap
    cpu_write(16'h8000, 8'h80);
    probe_all("R9");
    ppu_addr = 13'h0000; #1 check(chr_addr[17:10] == m_slot[2], "R9", 32'(chr_addr[17:10]), 32'(m_slot[2]));
    // R10 mirroring
    cpu_write(16'hA000, 8'h01);
    check(mirror_horiz == 1'b1, "R10", 32'(mirror_horiz), 1);
    cpu_write(16'hBFFF, 8'h00);
    check(mirror_horiz == 1'b1, "R10", 32'(mirror_horiz), 1);
    cpu_write(16'hBFFE, 8'hFE);
    check(mirror_horiz == 1'b0, "R10", 32'(mirror_horiz), 0);
    // R2 writes outside the mapped registers change nothing
    cpu_write(16'h7000, 8'hFF);
    cpu_write(16'h7001, 8'hFF);
    cpu_write(16'h0000, 8'h47);
    cpu_write(16'hC000, 8'hFF); cpu_write(16'hC001, 8'hFF);
    cpu_write(16'hE000, 8'hFF); cpu_write(16'hE001, 8'hFF);
    probe_all("R2");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (($urandom % 3) != 0) a = {1'b1, 2'($urandom % 2) == 0 ? 2'b00 : 2'($urandom), a[12:0]};
      cpu_write(a, 8'($urandom));
      probe_prg({1'b1, 15'($urandom)}, "R4/R5/R6/R7");
      probe_chr(13'($urandom), "R8/R9");
      check(mirror_horiz == m_mir, "R10", 32'(mirror_horiz), 32'(m_mir));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule